// File: doc/BRIEF.md
# Flash Sector Erase Sequencer

This block runs the erase of one sector in a parallel NOR flash array built from one or more identical devices that share a bus word. A single-cycle start pulse hands it the word address of the sector base and a poll budget. The sequencer then issues the six-write erase command sequence through a simple request/acknowledge bus master port, with every command byte copied into each device lane of the bus word.

Once the command sequence is out, the sequencer reads a status word at the sector's command offset until one of three outcomes. Every lane reports completion on its bit 7. A lane that is still busy raises its internal timeout on bit 5, in which case a reset command is written before stopping. Or the poll budget runs out. The outcome is reported on three sticky flags: done, timeout and error. These hold until the next accepted start. Only one sector is erased per start.

Top module: `nor_sector_eraser`

## Requirements
- R1: After reset, busy_o, done_o, timeout_o, error_o and bus_req_o are all 0.
- R2: start_i is accepted only while busy_o is 0. An accepted start latches sector_base_i, clears all three flags and raises busy_o from the next cycle. A start while busy_o is 1 has no effect on the addresses or the number of transfers.
- R3: The command phase is six writes, in this order: offset 0x555 data 0xAA, 0x2AA 0x55, 0x555 0x80, 0x555 0xAA, 0x2AA 0x55, 0x555 0x30. Offsets are added to the latched base, in word units. Each lane k occupies bus bits [k*LW +: LW], where LW = DATA_W/LANES. Each lane carries the command byte zero-extended to LW bits, so with 16 bits and two lanes 0xAA appears as 0xAAAA.
- R4: A bus transfer holds bus_req_o, bus_we_o, bus_addr_o and bus_wdata_o steady until the cycle in which bus_ack_i is 1.
- R5: After the last command write, the sequencer repeatedly reads (bus_we_o = 0) at base + 0x555 until an outcome is reached.
- R6: A poll read in which bit 7 of every lane is 1 ends the erase with done_o = 1.
- R7: A poll read in which some lane has bit 7 = 0 and bit 5 = 1 causes one write of 0xF0 (in every lane) at base + 0x555, after which error_o = 1. Bit 5 of a lane whose bit 7 is 1 is ignored.
- R8: Each poll read consumes one unit of the budget captured at start. When the budget is used up without an outcome, timeout_o = 1 with no further transfers. A budget of 0 behaves as 1.
- R9: At most one of done_o, timeout_o and error_o is 1 at any time. All three are 0 while busy_o is 1. A flag stays set until the next accepted start.
- R10: Completion takes priority: a read with every bit 7 set ends in done even if bit 5 is also set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse for one sector erase |
| sector_base_i | input | ADDR_W | Word address of the sector base |
| poll_budget_i | input | BUDGET_W | Maximum number of status reads |
| busy_o | output | 1 | Erase in progress |
| done_o | output | 1 | Erase finished successfully (sticky) |
| timeout_o | output | 1 | Poll budget exhausted (sticky) |
| error_o | output | 1 | Device timeout seen and reset issued (sticky) |
| bus_req_o | output | 1 | Bus transfer request |
| bus_we_o | output | 1 | 1 = write, 0 = read |
| bus_addr_o | output | ADDR_W | Bus word address |
| bus_wdata_o | output | DATA_W | Write data, command replicated per lane |
| bus_ack_i | input | 1 | Transfer completes in this cycle |
| bus_rdata_i | input | DATA_W | Read data, valid with bus_ack_i on reads |

## Verification
The assertions check several properties on every cycle:
- the outcome flags are exclusive and stay silent while busy;
- a pending transfer holds its request, direction, address and data until acknowledged;
- every read targets the latched base plus 0x555;
- an error flag is always preceded by an acknowledged 0xF0 write;
- a done flag is always preceded by a read in which every lane's bit 7 was set.

Only the bench's scenarios can show the rest:
- the exact order and values of the six command writes;
- the per-lane masking of bit 5;
- the priority of completion over fault;
- the exact read count for a given budget, including the zero-budget case;
- that a start during an erase changes nothing.

// File: rtl/nse_pkg.sv
package nse_pkg;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_CMD  = 2'd1,
      ST_POLL = 2'd2,
      ST_RST  = 2'd3
   } nse_state_e;

   localparam int         CMD_STEPS  = 6;
   localparam int         STEP_W     = 3;
   localparam int         OFF_W      = 12;
   localparam logic [OFF_W-1:0] OFF_MAIN = 12'h555;
   localparam logic [OFF_W-1:0] OFF_ALT  = 12'h2AA;
   localparam logic [7:0] BYTE_RESET = 8'hF0;

   // word offset of a command step (relative to the sector base)
   function automatic logic [OFF_W-1:0] step_offset(input logic [STEP_W-1:0] step);
      case (step)
         3'd1, 3'd4: step_offset = OFF_ALT;
         default:    step_offset = OFF_MAIN;
      endcase
   endfunction

   // command byte of a step
   function automatic logic [7:0] step_byte(input logic [STEP_W-1:0] step);
      case (step)
         3'd0, 3'd3: step_byte = 8'hAA;
         3'd1, 3'd4: step_byte = 8'h55;
         3'd2:       step_byte = 8'h80;
         default:    step_byte = 8'h30;
      endcase
   endfunction

endpackage

// File: rtl/nse_lane_fill.sv
module nse_lane_fill #(
   parameter int DATA_W = 16,
   parameter int LANES  = 2
) (
   input  logic [7:0]        byte_i,
   output logic [DATA_W-1:0] word_o
);
   localparam int LW = DATA_W / LANES;

   for (genvar k = 0; k < LANES; k++) begin : g_lane
      if (LW > 8) begin : g_wide
         assign word_o[k*LW +: LW] = {{(LW-8){1'b0}}, byte_i};
      end else begin : g_byte
         assign word_o[k*LW +: LW] = byte_i;
      end
   end
endmodule

// File: rtl/nse_status_eval.sv
module nse_status_eval #(
   parameter int DATA_W = 16,
   parameter int LANES  = 2
) (
   input  logic [DATA_W-1:0] rdata_i,
   output logic              all_ready_o,
   output logic              fault_o
);
   localparam int LW = DATA_W / LANES;

   logic [LANES-1:0] ready_v;
   logic [LANES-1:0] fault_v;

   for (genvar k = 0; k < LANES; k++) begin : g_lane
      // bit 7 of the lane: operation finished
      assign ready_v[k] = rdata_i[k*LW + 7];
      // bit 5 only matters while the lane is still working
      assign fault_v[k] = ~rdata_i[k*LW + 7] & rdata_i[k*LW + 5];
   end

   assign all_ready_o = &ready_v;
   assign fault_o     = |fault_v;

   logic unused_rdata;
   assign unused_rdata = ^rdata_i;
endmodule

// File: rtl/nse_poll_budget.sv
module nse_poll_budget #(
   parameter int BUDGET_W = 16
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                load_i,
   input  logic [BUDGET_W-1:0] budget_i,
   input  logic                consume_i,
   output logic                last_o
);
   logic [BUDGET_W-1:0] remain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         remain_q <= '0;
      end else if (load_i) begin
         remain_q <= (budget_i == '0) ? BUDGET_W'(1) : budget_i;
      end else if (consume_i && remain_q != '0) begin
         remain_q <= remain_q - BUDGET_W'(1);
      end
   end

   // the read now in flight is the final one allowed
   assign last_o = (remain_q <= BUDGET_W'(1));
endmodule

// File: rtl/nor_sector_eraser.sv
module nor_sector_eraser
   import nse_pkg::*;
#(
   parameter int DATA_W   = 16,
   parameter int LANES    = 2,
   parameter int ADDR_W   = 24,
   parameter int BUDGET_W = 16
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                start_i,
   input  logic [ADDR_W-1:0]   sector_base_i,
   input  logic [BUDGET_W-1:0] poll_budget_i,
   output logic                busy_o,
   output logic                done_o,
   output logic                timeout_o,
   output logic                error_o,
   output logic                bus_req_o,
   output logic                bus_we_o,
   output logic [ADDR_W-1:0]   bus_addr_o,
   output logic [DATA_W-1:0]   bus_wdata_o,
   input  logic                bus_ack_i,
   input  logic [DATA_W-1:0]   bus_rdata_i
);
   localparam int LW = DATA_W / LANES;

   // elaboration-time parameter checks
   if (LANES < 1) begin : g_chk_lanes
      $error("LANES must be at least 1");
   end
   if (DATA_W % LANES != 0) begin : g_chk_div
      $error("DATA_W must divide evenly into LANES");
   end
   if (LW < 8) begin : g_chk_lw
      $error("each lane needs at least 8 bits");
   end
   if (ADDR_W < OFF_W) begin : g_chk_addr
      $error("ADDR_W too small for command offsets");
   end
   if (BUDGET_W < 1) begin : g_chk_budget
      $error("BUDGET_W must be at least 1");
   end

   nse_state_e          state_q;
   logic [STEP_W-1:0]   step_q;
   logic [ADDR_W-1:0]   base_q;
   logic                done_q, timeout_q, error_q;

   logic                accept;
   logic                all_ready, fault, last_read;
   logic                poll_ack;
   logic [7:0]          cmd_byte;
   logic [OFF_W-1:0]    cmd_off;

   assign accept   = start_i && (state_q == ST_IDLE);
   assign poll_ack = (state_q == ST_POLL) && bus_ack_i;

   nse_status_eval #(.DATA_W(DATA_W), .LANES(LANES)) i_eval (
      .rdata_i     (bus_rdata_i),
      .all_ready_o (all_ready),
      .fault_o     (fault)
   );

   nse_poll_budget #(.BUDGET_W(BUDGET_W)) i_budget (
      .clk       (clk),
      .rst_n     (rst_n),
      .load_i    (accept),
      .budget_i  (poll_budget_i),
      .consume_i (poll_ack),
      .last_o    (last_read)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= ST_IDLE;
         step_q    <= '0;
         base_q    <= '0;
         done_q    <= 1'b0;
         timeout_q <= 1'b0;
         error_q   <= 1'b0;
      end else begin
         case (state_q)
            ST_IDLE: begin
               if (start_i) begin
                  base_q    <= sector_base_i;
                  step_q    <= '0;
                  done_q    <= 1'b0;
                  timeout_q <= 1'b0;
                  error_q   <= 1'b0;
                  state_q   <= ST_CMD;
               end
            end
            ST_CMD: begin
               if (bus_ack_i) begin
                  if (step_q == STEP_W'(CMD_STEPS - 1)) begin
                     state_q <= ST_POLL;
                  end else begin
                     step_q <= step_q + STEP_W'(1);
                  end
               end
            end
            ST_POLL: begin
               if (bus_ack_i) begin
                  if (all_ready) begin
                     done_q  <= 1'b1;
                     state_q <= ST_IDLE;
                  end else if (fault) begin
                     state_q <= ST_RST;
                  end else if (last_read) begin
                     timeout_q <= 1'b1;
                     state_q   <= ST_IDLE;
                  end
               end
            end
            ST_RST: begin
               if (bus_ack_i) begin
                  error_q <= 1'b1;
                  state_q <= ST_IDLE;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   always_comb begin
      if (state_q == ST_CMD) begin
         cmd_off  = step_offset(step_q);
         cmd_byte = step_byte(step_q);
      end else begin
         cmd_off  = OFF_MAIN;
         cmd_byte = BYTE_RESET;
      end
   end

   nse_lane_fill #(.DATA_W(DATA_W), .LANES(LANES)) i_fill (
      .byte_i (cmd_byte),
      .word_o (bus_wdata_o)
   );

   assign bus_req_o  = (state_q != ST_IDLE);
   assign bus_we_o   = (state_q == ST_CMD) || (state_q == ST_RST);
   assign bus_addr_o = base_q + ADDR_W'(cmd_off);

   assign busy_o    = (state_q != ST_IDLE);
   assign done_o    = done_q;
   assign timeout_o = timeout_q;
   assign error_o   = error_q;
endmodule

// File: rtl/nse_checker.sv
module nse_checker #(
   parameter int DATA_W = 16,
   parameter int LANES  = 2,
   parameter int ADDR_W = 24
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start_i,
   input logic [ADDR_W-1:0] sector_base_i,
   input logic              busy_o,
   input logic              done_o,
   input logic              timeout_o,
   input logic              error_o,
   input logic              bus_req_o,
   input logic              bus_we_o,
   input logic [ADDR_W-1:0] bus_addr_o,
   input logic [DATA_W-1:0] bus_wdata_o,
   input logic              bus_ack_i,
   input logic [DATA_W-1:0] bus_rdata_i
);
   localparam int LW = DATA_W / LANES;

   logic [ADDR_W-1:0] base_seen;
   logic [DATA_W-1:0] reset_word;
   logic              rd_all7;

   always_comb begin
      rd_all7 = 1'b1;
      for (int k = 0; k < LANES; k++) begin
         rd_all7 = rd_all7 & bus_rdata_i[k*LW + 7];
         reset_word[k*LW +: LW] = LW'(8'hF0);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) base_seen <= '0;
      else if (start_i && !busy_o) base_seen <= sector_base_i;
   end

   logic unused_chk;
   assign unused_chk = ^bus_rdata_i;

   a_r9_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({done_o, timeout_o, error_o}));

   a_r9_quiet_busy: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o |-> !(done_o || timeout_o || error_o));

   a_r1_req_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
      bus_req_o |-> busy_o);

   a_r4_hold_pending: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req_o && !bus_ack_i) |=> (bus_req_o && $stable(bus_we_o) &&
                                     $stable(bus_addr_o) && $stable(bus_wdata_o)));

   a_r5_poll_target: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req_o && !bus_we_o) |-> (bus_addr_o == base_seen + ADDR_W'(12'h555)));

   a_r7_error_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(error_o) |-> $past(bus_req_o && bus_ack_i && bus_we_o && (bus_wdata_o == reset_word)));

   a_r6_done_after_ready: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done_o) |-> $past(bus_req_o && bus_ack_i && !bus_we_o && rd_all7));
endmodule

bind nor_sector_eraser nse_checker #(
   .DATA_W(DATA_W), .LANES(LANES), .ADDR_W(ADDR_W)
) i_nse_checker (
   .clk           (clk),
   .rst_n         (rst_n),
   .start_i       (start_i),
   .sector_base_i (sector_base_i),
   .busy_o        (busy_o),
   .done_o        (done_o),
   .timeout_o     (timeout_o),
   .error_o       (error_o),
   .bus_req_o     (bus_req_o),
   .bus_we_o      (bus_we_o),
   .bus_addr_o    (bus_addr_o),
   .bus_wdata_o   (bus_wdata_o),
   .bus_ack_i     (bus_ack_i),
   .bus_rdata_i   (bus_rdata_i)
);

// File: tb/test_nor_sector_eraser.sv
`timescale 1ns/1ps
module test_nor_sector_eraser;
   localparam int DATA_W = 16, LANES = 2, ADDR_W = 24, BUDGET_W = 16;

   logic clk = 1'b0, rst_n = 1'b0;
   logic start = 1'b0;
   logic [ADDR_W-1:0] base = '0;
   logic [BUDGET_W-1:0] budget = '0;
   logic busy, done, tmo, err, req, we, ack = 1'b0;
   logic [ADDR_W-1:0] addr;
   logic [DATA_W-1:0] wdata, rdata = '0;

   always #2.5 clk = ~clk;

   nor_sector_eraser #(.DATA_W(DATA_W), .LANES(LANES), .ADDR_W(ADDR_W), .BUDGET_W(BUDGET_W))
   i_nor_sector_eraser (
      .clk(clk), .rst_n(rst_n), .start_i(start), .sector_base_i(base),
      .poll_budget_i(budget), .busy_o(busy), .done_o(done), .timeout_o(tmo),
      .error_o(err), .bus_req_o(req), .bus_we_o(we), .bus_addr_o(addr),
      .bus_wdata_o(wdata), .bus_ack_i(ack), .bus_rdata_i(rdata));

   int n_chk = 0, n_bad = 0;

   // bus responder state
   logic [15:0] script [0:15];
   int          script_len = 1;
   int          rd_idx = 0;
   int          log_n = 0;
   logic        log_we   [0:63];
   logic [23:0] log_addr [0:63];
   logic [15:0] log_data [0:63];

   task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // responder: one-cycle ack, driven at the falling edge
   initial begin
      forever begin
         @(negedge clk);
         if (ack) ack = 1'b0;
         else if (req) begin
            ack = 1'b1;
            if (log_n < 64) begin
               log_we[log_n] = we; log_addr[log_n] = addr; log_data[log_n] = wdata;
               log_n++;
            end
            if (!we) begin
               rdata = script[(rd_idx < script_len) ? rd_idx : script_len - 1];
               rd_idx++;
            end
         end
      end
   end

   task automatic clear_log();
      log_n = 0; rd_idx = 0;
   endtask

   task automatic run_erase(input logic [23:0] b, input logic [15:0] bud, input string tag);
      @(negedge clk);
      base = b; budget = bud; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk(busy === 1'b1, {tag, " R2 busy after start"}, busy, 1);
      for (int i = 0; i < 2000 && busy; i++) @(negedge clk);
   endtask

   task automatic check_cmds(input logic [23:0] b, input string tag);
      logic [11:0] offs [0:5];
      logic [15:0] dats [0:5];
      offs = '{12'h555, 12'h2AA, 12'h555, 12'h555, 12'h2AA, 12'h555};
      dats = '{16'hAAAA, 16'h5555, 16'h8080, 16'hAAAA, 16'h5555, 16'h3030};
      for (int i = 0; i < 6; i++) begin
         chk(log_we[i] === 1'b1 && log_addr[i] === b + 24'(offs[i]),
             {tag, " R3 command address"}, log_addr[i], b + 24'(offs[i]));
         chk(log_data[i] === dats[i], {tag, " R3 command data"}, log_data[i], dats[i]);
      end
   endtask

   task automatic check_reads(input logic [23:0] b, input int first, input int last, input string tag);
      for (int i = first; i <= last; i++)
         chk(log_we[i] === 1'b0 && log_addr[i] === b + 24'h555,
             {tag, " R5 poll read address"}, log_addr[i], b + 24'h555);
   endtask

   task automatic t_reset();
      chk(!busy && !done && !tmo && !err && !req, "R1 reset state",
          {busy, done, tmo, err, req}, 0);
   endtask

   task automatic t_done();
      clear_log();
      script[0] = 16'h0000; script[1] = 16'h0080; script[2] = 16'h8080; script_len = 3;
      run_erase(24'h010000, 16'd10, "done");
      chk(log_n == 9, "R6 transfer count", log_n, 9);
      check_cmds(24'h010000, "done");
      check_reads(24'h010000, 6, 8, "done");
      chk(done && !tmo && !err && !busy, "R6 done flag", {done, tmo, err}, 3'b100);
      repeat (3) @(negedge clk);
      chk(done === 1'b1 && !req, "R9 done flag held", done, 1);
   endtask

   task automatic t_fault();
      clear_log();
      script[0] = 16'h0000; script[1] = 16'h2000; script_len = 2;
      run_erase(24'h020000, 16'd10, "fault");
      chk(log_n == 9, "R7 transfer count", log_n, 9);
      check_cmds(24'h020000, "fault");
      chk(log_we[8] === 1'b1 && log_addr[8] === 24'h020555 && log_data[8] === 16'hF0F0,
          "R7 reset write", log_data[8], 16'hF0F0);
      chk(err && !done && !tmo, "R7 error flag", {done, tmo, err}, 3'b001);
   endtask

   task automatic t_masked();
      clear_log();
      script[0] = 16'h00A0; script[1] = 16'h8080; script_len = 2;
      run_erase(24'h030000, 16'd10, "masked");
      chk(log_n == 8 && done && !err, "R7 bit5 ignored on ready lane", {log_n[7:0], done, err}, {8'd8, 2'b10});
   endtask

   task automatic t_priority();
      clear_log();
      script[0] = 16'hA0A0; script_len = 1;
      run_erase(24'h040000, 16'd10, "prio");
      chk(log_n == 7 && done && !err, "R10 completion before fault", {log_n[7:0], done, err}, {8'd7, 2'b10});
   endtask

   task automatic t_timeout(input logic [15:0] bud, input int exp_reads);
      clear_log();
      script[0] = 16'h0000; script_len = 1;
      run_erase(24'h050000, bud, "timeout");
      chk(log_n == 6 + exp_reads, "R8 read count", log_n, 6 + exp_reads);
      check_reads(24'h050000, 6, 5 + exp_reads, "timeout");
      chk(tmo && !done && !err, "R8 timeout flag", {done, tmo, err}, 3'b010);
   endtask

   task automatic t_start_busy();
      clear_log();
      script[0] = 16'h0000; script[1] = 16'h0000; script[2] = 16'h8080; script_len = 3;
      @(negedge clk);
      base = 24'h060000; budget = 16'd10; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk(!done && !tmo && !err, "R9 flags cleared on start", {done, tmo, err}, 0);
      repeat (3) @(negedge clk);
      base = 24'h070000; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      for (int i = 0; i < 2000 && busy; i++) @(negedge clk);
      chk(log_n == 9, "R2 start while busy ignored count", log_n, 9);
      check_cmds(24'h060000, "busy-start R2");
      check_reads(24'h060000, 6, 8, "busy-start R2");
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_done();
      t_fault();
      t_masked();
      t_priority();
      t_timeout(16'd4, 4);
      t_timeout(16'd0, 1);
      t_start_busy();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule